// File: doc/BRIEF.md
# Fractional Rate Bit Multiplier

This block lets a transmitter whose serializer always runs at a fixed fast bit rate send a stream at a slower rate. It stretches each slow-rate bit over a whole number of fast bit times. The hold length follows a fixed five-slot group of 3, 3, 4, 3 and 3 fast cycles, so five slow bits fill sixteen fast cycles. This gives a 16:5 ratio, and the average is exact even though no single bit has that length. The uneven hold lengths add a small, deterministic timing jitter, and the design accepts it.

Slow-rate bits arrive with a ready/valid handshake. One bit leaves per clock on `out_bit`. A mode input picks between two behaviours. The multiplied mode is used while the link trains at the low rate. The pass-through mode, used after the speed change, forwards each bit at the native fast rate through a single register. Mode changes wait for the end of a five-slot group, so a group is never cut short in multiplied mode.

A two-state controller (`ST_PASS`, `ST_MUL`) sits over a slot timer. The slot timer holds a group phase counter (0 to 4) and a repeat counter. The controller has four transitions. `ST_PASS` stays in `ST_PASS` while `mode_mul` is 0. `ST_PASS` goes to `ST_MUL` on the first cycle that `mode_mul` is 1. `ST_MUL` stays in `ST_MUL` on every cycle except the last cycle of the phase-4 slot. `ST_MUL` goes to `ST_PASS` on the last cycle of the phase-4 slot when `mode_mul` is 0.

Top module: `frac_rate_bit_mult`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_bit` is 0 and `in_ready` is 1. The block is in pass-through state with both counters cleared.
- R2: In multiplied mode (`mode_mul` = 1), the slot of group phase p lasts 4 fast cycles when p = 2 and 3 cycles otherwise. A fully fed stream of 10 slow bits therefore occupies exactly 32 fast cycles.
- R3: In multiplied mode, `in_ready` is 1 only on the last fast cycle of a slot. A bit taken when `in_ready` and `in_valid` are both 1 appears on `out_bit` on the next cycle and stays unchanged until the next taken bit.
- R4: The group phase advances by one only when a bit is taken. It wraps from 4 back to 0.
- R5: If `in_valid` is 0 on the last cycle of a slot, no bit is taken. `out_bit` repeats the previous bit for another slot, and that slot has the same length because the phase is unchanged.
- R6: In pass-through mode, `in_ready` is constantly 1. When `in_valid` is 1, `out_bit` equals `in_bit` one cycle later. When `in_valid` is 0, `out_bit` holds its value.
- R7: A request for pass-through (`mode_mul` = 0) made during multiplied mode takes effect only on the last cycle of the phase-4 slot. The bit taken on that cycle is output for a single cycle, and pass-through follows.
- R8: When `mode_mul` = 1 is seen in pass-through mode, the bit taken on that cycle becomes the phase-0 slot of a new group and is held for 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-rate bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mul | input | 1 | 1 = multiplied (slow-rate) mode, 0 = pass-through |
| in_bit | input | 1 | Slow-rate data bit |
| in_valid | input | 1 | `in_bit` is valid |
| in_ready | output | 1 | Block takes `in_bit` this cycle if `in_valid` is 1 |
| out_bit | output | 1 | Fast-rate output bit, one per clock |

## Verification
The bench targets several corner cases, each tied to the failure it would expose:
- The single long slot at phase 2. A design that placed it elsewhere, or made every slot 3 cycles, would shift the ready pulses and end a ten-bit run before cycle 32.
- A stall on the last cycle of the long slot. A design that advanced the phase anyway would shorten the repeated slot and misalign the rest of the group.
- A pass-through request raised mid-group. A design that switched at once would raise `in_ready` early and truncate a slot.
- The hand-over cycles in both directions. A design that lost or doubled the bit taken on the switching cycle would miscompare immediately.
- Input bits that toggle while `in_ready` is low. These would leak onto `out_bit` in a design that sampled its input without the handshake.

// File: rtl/frm_pkg.sv
package frm_pkg;

    typedef enum logic [0:0] {
        ST_PASS = 1'b0,
        ST_MUL  = 1'b1
    } frm_state_e;

endpackage

// File: rtl/frm_slot_timer.sv
module frm_slot_timer #(
    parameter int GROUP_LEN  = 5,
    parameter int BASE_HOLD  = 3,
    parameter int LONG_PHASE = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          adv,
    output logic                          slot_end,
    output logic                          group_end,
    output logic [$clog2(GROUP_LEN)-1:0]  phase
);
    localparam int PH_W = $clog2(GROUP_LEN);
    localparam int RP_W = $clog2(BASE_HOLD + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_LEN - 1);
    localparam logic [PH_W-1:0] PH_LONG = PH_W'(LONG_PHASE);
    localparam logic [RP_W-1:0] REP_SHORT_END = RP_W'(BASE_HOLD - 1);
    localparam logic [RP_W-1:0] REP_LONG_END  = RP_W'(BASE_HOLD);

    logic [PH_W-1:0] phase_q;
    logic [RP_W-1:0] rep_q;
    logic [RP_W-1:0] rep_end;

    always_comb begin
        rep_end   = (phase_q == PH_LONG) ? REP_LONG_END : REP_SHORT_END;
        slot_end  = run && (rep_q == rep_end);
        group_end = slot_end && (phase_q == PH_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            rep_q   <= '0;
        end else if (!run) begin
            phase_q <= '0;
            rep_q   <= '0;
        end else if (slot_end) begin
            rep_q <= '0;
            if (adv) begin
                phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            end
        end else begin
            rep_q <= rep_q + 1'b1;
        end
    end

    assign phase = phase_q;

    // Slots last at least two cycles, so two ready pulses never touch.
    assert_slot_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> !slot_end);

    assert_phase_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && adv && phase_q == PH_LAST) |=> (phase_q == '0));

    assert_stall_keeps_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && !adv && !group_end) |=> ($stable(phase_q) && rep_q == '0));

endmodule

// File: rtl/frm_mode_fsm.sv
module frm_mode_fsm
    import frm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_mul,
    input  logic       in_valid,
    input  logic       slot_end,
    input  logic       group_end,
    output frm_state_e state,
    output logic       in_ready,
    output logic       load,
    output logic       run
);
    frm_state_e state_q;
    frm_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: if (mode_mul)                 state_d = ST_MUL;
            ST_MUL:  if (group_end && !mode_mul)   state_d = ST_PASS;
            default:                               state_d = ST_PASS;
        endcase
    end

    always_comb begin
        in_ready = 1'b1;
        run      = 1'b0;
        unique case (state_q)
            ST_PASS: begin
                in_ready = 1'b1;
                run      = 1'b0;
            end
            ST_MUL: begin
                in_ready = slot_end;
                run      = 1'b1;
            end
            default: begin
                in_ready = 1'b1;
                run      = 1'b0;
            end
        endcase
        load = in_ready && in_valid;
    end

    assign state = state_q;

    assert_mode_change_at_group_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL && !group_end) |=> (state_q == ST_MUL));

endmodule

// File: rtl/frm_bit_hold.sv
module frm_bit_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/frac_rate_bit_mult.sv
module frac_rate_bit_mult #(
    parameter int GROUP_LEN  = 5,
    parameter int BASE_HOLD  = 3,
    parameter int LONG_PHASE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_mul,
    input  logic in_bit,
    input  logic in_valid,
    output logic in_ready,
    output logic out_bit
);
    import frm_pkg::*;

    localparam int PH_W = $clog2(GROUP_LEN);

    frm_state_e      state;
    logic            load;
    logic            run;
    logic            slot_end;
    logic            group_end;
    logic [PH_W-1:0] phase;

    frm_slot_timer #(
        .GROUP_LEN (GROUP_LEN),
        .BASE_HOLD (BASE_HOLD),
        .LONG_PHASE(LONG_PHASE)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .adv      (load),
        .slot_end (slot_end),
        .group_end(group_end),
        .phase    (phase)
    );

    frm_mode_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_mul (mode_mul),
        .in_valid (in_valid),
        .slot_end (slot_end),
        .group_end(group_end),
        .state    (state),
        .in_ready (in_ready),
        .load     (load),
        .run      (run)
    );

    frm_bit_hold hold_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .d    (in_bit),
        .q    (out_bit)
    );

    assert_hold_between_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && in_valid) |=> $stable(out_bit));

    assert_take_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (out_bit == $past(in_bit)));

    assert_pass_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> in_ready);

    assert_enter_mul_phase0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && mode_mul) |=> (!in_ready && phase == '0));

endmodule

// File: tb/frac_rate_bit_mult_tb.sv
`timescale 1ns/1ps
module frac_rate_bit_mult_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_mul = 1'b0;
    logic in_bit = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic out_bit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    frac_rate_bit_mult dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_mul(mode_mul),
        .in_bit  (in_bit),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .out_bit (out_bit)
    );

    // {mode_mul, in_valid, in_bit, expected in_ready, expected out_bit}
    localparam int NV = 26;
    localparam logic [4:0] VEC [NV] = '{
        5'b01110, // 0  R1 reset state, R6 take 1
        5'b01011, // 1  R6 out follows in one cycle later
        5'b00110, // 2  R6 valid low holds out
        5'b11110, // 3  R8 switch request, take 1
        5'b11001, // 4  R8 phase 0 slot, toggled bit ignored (R3)
        5'b11001, // 5
        5'b11011, // 6  R3 ready on last cycle, take 0
        5'b11100, // 7  R2 phase 1
        5'b11100, // 8
        5'b11110, // 9  take 1
        5'b11001, // 10 R2 long phase 2 slot
        5'b11001, // 11
        5'b11001, // 12
        5'b10011, // 13 R5 stall at end of long slot
        5'b11001, // 14 R5 repeated long slot
        5'b11001, // 15
        5'b11001, // 16
        5'b11011, // 17 R4 take 0, phase advances
        5'b11100, // 18 phase 3
        5'b11100, // 19
        5'b11110, // 20 take 1
        5'b01001, // 21 R7 early pass request ignored
        5'b01001, // 22 R7
        5'b01011, // 23 R7 group end: take 0, switch
        5'b01110, // 24 R7 bit shown one cycle, pass again
        5'b00011  // 25 R6 hold
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        logic        cur;
        int          cycles;

        // R1: values while in reset
        repeat (3) @(negedge clk);
        check("R1", "out_bit in reset", out_bit, 1'b0);
        check("R1", "in_ready in reset", in_ready, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            check("vec", $sformatf("ready v%0d", i), in_ready, VEC[i][1]);
            check("vec", $sformatf("out v%0d", i), out_bit, VEC[i][0]);
            mode_mul = VEC[i][4];
            in_valid = VEC[i][3];
            in_bit   = VEC[i][2];
            @(negedge clk);
        end

        // R1: reset in the middle of activity
        mode_mul = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "out_bit after mid reset", out_bit, 1'b0);
        check("R1", "in_ready after mid reset", in_ready, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R4: ten fully fed slow bits, lengths 3,3,4,3,3 twice, 32 cycles
        pat = 16'b1011_0010_1110_0101;
        mode_mul = 1'b1; in_valid = 1'b1; in_bit = pat[0];
        @(negedge clk);
        cur = pat[0];
        cycles = 0;
        for (int s = 0; s < 10; s++) begin
            int len;
            len = ((s % 5) == 2) ? 4 : 3;
            for (int k = 1; k <= len; k++) begin
                check("R2", $sformatf("ready slot%0d k%0d", s, k), in_ready, (k == len));
                check("R3", $sformatf("out slot%0d k%0d", s, k), out_bit, cur);
                in_bit = pat[s + 1];
                cycles++;
                @(negedge clk);
            end
            cur = pat[s + 1];
        end
        n_checks++;
        if (cycles != 32) begin
            n_fails++;
            $display("FAIL R2 span actual=%0d expected=32", cycles);
        end
        // R4: phase wrapped, so the next slot is phase 0 (3 cycles)
        check("R4", "first cycle after wrap", in_ready, 1'b0);
        check("R4", "out after wrap", out_bit, cur);
        @(negedge clk);
        check("R4", "second cycle after wrap", in_ready, 1'b0);
        @(negedge clk);
        check("R4", "third cycle after wrap", in_ready, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule